// File: doc/BRIEF.md
# Pipelined Vector Rotator (Circular CORDIC)

This block turns a two's-complement vector (x, y) through a signed angle using a chain of shift-and-add stages, one stage per elementary rotation, with a register after each stage. The output is the rotated vector multiplied by the fixed CORDIC gain K (about 1.6468 for 16 stages), plus whatever angle is left over at the end of the chain. If the input vector is (1/K, 0) in full-scale units, then the two outputs are the cosine and sine of the angle. This is how a digital I/Q mixer or demodulator obtains its local-oscillator samples without a sine table.

Angles use the whole signed word to span ±π, so +π/2 is 0x4000 in a 16-bit word. Each stage looks only at the sign of its running angle. It adds or subtracts a fixed arctangent constant, and adds or subtracts copies of x and y shifted right by its own index. These shifts are fixed wiring, so no shifter hardware and no direction memory are needed. Internally, x and y carry two extra integer bits so the gain cannot wrap the value, and four extra fraction bits to keep rounding error low. The running angle carries four extra fraction bits. The outputs keep the two integer guard bits and drop the fraction bits by flooring.

A valid flag travels with each sample. A synchronous reset clears every valid flag in the chain and leaves the data registers untouched.

Top module: `rcordic`

## Requirements
- R1: `out_valid` rises exactly STAGES clock cycles after the cycle in which `in_valid` was sampled high, and carries that sample's result. Back-to-back inputs produce back-to-back outputs, one per clock, and idle input cycles produce idle output cycles.
- R2: Take θ = `in_ang`·π/2^(AW-1) and K = ∏ sqrt(1+2^-2i) over the stages. For |θ| ≤ π/2, `out_x` is within 4 LSB of K·(x·cosθ − y·sinθ), and `out_y` is within 4 LSB of K·(x·sinθ + y·cosθ).
- R3: Inputs at the full-scale corners (for example x = y = −32768) come out correct to the same tolerance, without wrapping. Outputs are DW+2 bits wide. At no stage does the squared vector length shrink by more than the rounding slack of that stage.
- R4: For |`in_ang`| ≤ 0x4000, `out_resid` (the leftover angle, same scale as `in_ang`) lies within ±2 codes of zero. At each stage the magnitude of the running angle does not exceed the larger of its previous magnitude and that stage's arctangent constant.
- R5: The end points `in_ang` = 0x4000 (+π/2) and 0xC000 (−π/2) converge and meet R2. With x = round(32767/K) and y = 0 they give (0, +32767) and (0, −32767) within tolerance.
- R6: While `rst` is high at a clock edge, every valid flag in the chain clears. `out_valid` is 0 in the cycle after reset, and samples that were in flight when reset arrived never appear at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears valid flags only |
| in_valid | input | 1 | Input sample qualifier |
| in_x | input | DW | Input x, two's complement |
| in_y | input | DW | Input y, two's complement |
| in_ang | input | AW | Rotation angle, full scale ±π |
| out_valid | output | 1 | Result qualifier, STAGES cycles after input |
| out_x | output | DW+2 | Rotated x times gain K |
| out_y | output | DW+2 | Rotated y times gain K |
| out_resid | output | AW | Leftover angle after the last stage |

## Verification
On every cycle, the assertions check three things: that each stage's valid flag only follows a valid flag on the stage before it, that the running angle never grows past the bound set by that stage's constant, and that the vector length never shrinks by more than rounding. They also check that reset empties the output. Only the bench's scenarios can show the numerical accuracy against real-valued cosine and sine, the exact STAGES-cycle alignment under streaming and gapped traffic, the correct handling of the ±π/2 end points and the full-scale corners, and the loss of in-flight samples when reset arrives mid-stream.

// File: rtl/rcordic_pkg.sv
package rcordic_pkg;

    // Guard bits added around the external widths
    localparam int INT_GUARD  = 2;   // headroom for gain up to ~1.65 and diagonal inputs
    localparam int FRAC_GUARD = 4;   // extra x/y fraction bits against truncation bias
    localparam int ANG_GUARD  = 4;   // extra angle fraction bits against constant rounding

    localparam real PI_R = 3.14159265358979323846;

    // Direction of one elementary rotation, decided from the running angle sign
    typedef enum logic {
        DIR_POS = 1'b0,   // counter-clockwise, angle decreases by the constant
        DIR_NEG = 1'b1    // clockwise, angle increases by the constant
    } rot_dir_e;

    // arctan(2^-idx) expressed on a scale where 2^scale_bits represents pi
    function automatic longint atan_code(input int idx, input int scale_bits);
        real t;
        t = $atan(2.0 ** (-idx)) * (2.0 ** scale_bits) / PI_R;
        return longint'(t);
    endfunction

endpackage

// File: rtl/rcordic_stage.sv
module rcordic_stage
    import rcordic_pkg::*;
#(
    parameter int IDX = 0,
    parameter int XW  = 22,
    parameter int ZW  = 20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vi,
    input  logic signed [XW-1:0] xi,
    input  logic signed [XW-1:0] yi,
    input  logic signed [ZW-1:0] zi,
    output logic                 vo,
    output logic signed [XW-1:0] xo,
    output logic signed [XW-1:0] yo,
    output logic signed [ZW-1:0] zo
);

    localparam logic signed [ZW-1:0] STEP = ZW'(atan_code(IDX, ZW - 1));

    rot_dir_e             dir;
    logic signed [XW-1:0] x_sh, y_sh;
    logic signed [XW-1:0] x_nx, y_nx;
    logic signed [ZW-1:0] z_nx;

    assign dir  = zi[ZW-1] ? DIR_NEG : DIR_POS;
    // constant shifts: pure wiring, no shifter
    assign x_sh = xi >>> IDX;
    assign y_sh = yi >>> IDX;

    always_comb begin
        case (dir)
            DIR_POS: begin
                x_nx = xi - y_sh;
                y_nx = yi + x_sh;
                z_nx = zi - STEP;
            end
            default: begin
                x_nx = xi + y_sh;
                y_nx = yi - x_sh;
                z_nx = zi + STEP;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) vo <= 1'b0;
        else     vo <= vi;
    end

    always_ff @(posedge clk) begin
        xo <= x_nx;
        yo <= y_nx;
        zo <= z_nx;
    end

    // ---------------- assertions ----------------
    localparam int NW = 2 * XW + 4;

    logic signed [NW-1:0] xie, yie, xoe, yoe;
    logic signed [NW-1:0] n_in, n_out, slack;
    logic        [ZW:0]   zin_mag, zout_mag;
    logic        [ZW:0]   step_mag;

    assign xie      = NW'(xi);
    assign yie      = NW'(yi);
    assign xoe      = NW'(xo);
    assign yoe      = NW'(yo);
    assign n_in     = xie * xie + yie * yie;
    assign n_out    = xoe * xoe + yoe * yoe;
    assign slack    = (((xi[XW-1] ? -xie : xie) + (yi[XW-1] ? -yie : yie)) <<< 2) + NW'(8);
    assign zin_mag  = zi[ZW-1] ? (ZW+1)'(-(ZW+1)'(zi)) : (ZW+1)'(zi);
    assign zout_mag = zo[ZW-1] ? (ZW+1)'(-(ZW+1)'(zo)) : (ZW+1)'(zo);
    assign step_mag = (ZW+1)'(STEP);

    // R1: a valid flag here only ever follows a valid flag one stage earlier
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
        vo |-> $past(vi));

    // R4: the running angle stays within max(previous magnitude, this step)
    p_resid_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        vo |-> (zout_mag <= (($past(zin_mag) > step_mag) ? $past(zin_mag) : step_mag)));

    // R3: the squared length never drops by more than this stage's rounding slack
    p_norm_grows_r3: assert property (@(posedge clk) disable iff (rst)
        vo |-> (n_out + $past(slack) >= $past(n_in)));

endmodule

// File: rtl/rcordic.sv
module rcordic
    import rcordic_pkg::*;
#(
    parameter int DW     = 16,
    parameter int AW     = 16,
    parameter int STAGES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_x,
    input  logic signed [DW-1:0] in_y,
    input  logic signed [AW-1:0] in_ang,
    output logic                 out_valid,
    output logic signed [DW+1:0] out_x,
    output logic signed [DW+1:0] out_y,
    output logic signed [AW-1:0] out_resid
);

    localparam int XW = DW + INT_GUARD + FRAC_GUARD;
    localparam int ZW = AW + ANG_GUARD;
    localparam int OW = DW + INT_GUARD;

    logic                 v_l [0:STAGES];
    logic signed [XW-1:0] x_l [0:STAGES];
    logic signed [XW-1:0] y_l [0:STAGES];
    logic signed [ZW-1:0] z_l [0:STAGES];

    // widen inputs: sign bits on top, zero fraction bits below
    assign v_l[0] = in_valid;
    assign x_l[0] = $signed({{INT_GUARD{in_x[DW-1]}}, in_x, {FRAC_GUARD{1'b0}}});
    assign y_l[0] = $signed({{INT_GUARD{in_y[DW-1]}}, in_y, {FRAC_GUARD{1'b0}}});
    assign z_l[0] = $signed({in_ang, {ANG_GUARD{1'b0}}});

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        rcordic_stage #(
            .IDX (g),
            .XW  (XW),
            .ZW  (ZW)
        ) u_stage (
            .clk (clk),
            .rst (rst),
            .vi  (v_l[g]),
            .xi  (x_l[g]),
            .yi  (y_l[g]),
            .zi  (z_l[g]),
            .vo  (v_l[g+1]),
            .xo  (x_l[g+1]),
            .yo  (y_l[g+1]),
            .zo  (z_l[g+1])
        );
    end

    // drop guard fraction bits by flooring
    assign out_valid = v_l[STAGES];
    assign out_x     = x_l[STAGES][XW-1 -: OW];
    assign out_y     = y_l[STAGES][XW-1 -: OW];
    assign out_resid = z_l[STAGES][ZW-1 -: AW];

    // R6: reset empties the output in the following cycle
    p_reset_clears_r6: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/sim_rcordic.sv
module sim_rcordic;

    localparam int DW = 16;
    localparam int AW = 16;
    localparam int M  = 16;
    localparam real PI_V = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_x = '0;
    logic signed [DW-1:0] in_y = '0;
    logic signed [AW-1:0] in_ang = '0;
    logic                 out_valid;
    logic signed [DW+1:0] out_x, out_y;
    logic signed [AW-1:0] out_resid;

    always #4 clk = ~clk;   // 125 MHz

    rcordic #(.DW(DW), .AW(AW), .STAGES(M)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_ang(in_ang), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
        .out_resid(out_resid)
    );

    typedef struct {
        bit    v;
        int    x;
        int    y;
        int    a;
        string tag;
    } ent_t;

    ent_t  pipe_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    real   gain_k;
    string cur_tag = "R2";
    bit    post_rst = 1'b0;
    bit    done = 1'b0;

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, act, exp);
        end
    endtask

    // reference model: a queue of sampled inputs, STAGES deep
    always @(posedge clk) begin
        ent_t e;
        if (rst) begin
            foreach (pipe_q[i]) pipe_q[i].v = 1'b0;
        end
        e.v   = rst ? 1'b0 : in_valid;
        e.x   = int'(in_x);
        e.y   = int'(in_y);
        e.a   = int'(in_ang);
        e.tag = cur_tag;
        pipe_q.push_back(e);
    end

    always @(negedge clk) begin
        if (pipe_q.size() >= M) begin
            ent_t e;
            real  th, ex, ey;
            e = pipe_q.pop_front();
            chk(out_valid == e.v, post_rst ? "R6" : "R1", "out_valid",
                real'(out_valid), real'(e.v));
            if (e.v && out_valid) begin
                th = real'(e.a) * PI_V / (2.0 ** (AW - 1));
                ex = gain_k * (real'(e.x) * $cos(th) - real'(e.y) * $sin(th));
                ey = gain_k * (real'(e.x) * $sin(th) + real'(e.y) * $cos(th));
                chk(((real'(out_x) - ex) <= 4.0) && ((ex - real'(out_x)) <= 4.0),
                    e.tag, "out_x", real'(out_x), ex);
                chk(((real'(out_y) - ey) <= 4.0) && ((ey - real'(out_y)) <= 4.0),
                    e.tag, "out_y", real'(out_y), ey);
                chk((out_resid <= 2) && (out_resid >= -2), "R4", "out_resid",
                    real'(out_resid), 0.0);
            end
        end
    end

    task automatic send(input int x, input int y, input int a, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = DW'(x);
        in_y     = DW'(y);
        in_ang   = AW'(a);
        cur_tag  = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_x     = DW'(16'h5A5A);
            in_ang   = AW'(16'h1234);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        int unit;
        gain_k = 1.0;
        for (int i = 0; i < M; i++) gain_k = gain_k * $sqrt(1.0 + 2.0 ** (-2 * i));
        unit = int'(32767.0 / gain_k);

        repeat (3) @(negedge clk);
        // R6: reset state
        chk(out_valid == 1'b0, "R6", "out_valid in reset", real'(out_valid), 0.0);
        @(negedge clk);
        rst = 1'b0;

        // R2/R5: cosine/sine sweep over [-pi/2, +pi/2], streamed back to back
        for (int a = -16384; a <= 16384; a += 512)
            send(unit, 0, a, ((a == 16384) || (a == -16384)) ? "R5" : "R2");
        idle(M + 2);

        // R2: general vectors with gaps between them
        send(-12000, 7000, 16'h2000, "R2");
        idle(1);
        send(9000, -20000, -4096, "R2");
        idle(3);
        send(1, -1, 300, "R2");
        send(25000, 12345, -15000, "R2");
        send(-30000, -5, 0, "R2");
        idle(2);

        // R3: full-scale corners
        send(-32768, -32768, 0, "R3");
        send(32767, 32767, 16384, "R3");
        send(-32768, 0, -16384, "R3");
        send(32767, -32768, 8192, "R3");
        idle(M + 2);

        // R6: reset arriving with samples in flight
        for (int i = 0; i < 5; i++) send(unit, 0, i * 1000, "R2");
        @(negedge clk);
        rst      = 1'b1;
        post_rst = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;
        idle(M + 2);
        post_rst = 1'b0;

        // R1: stream resumes after reset
        send(unit, 0, 5461, "R2");
        send(unit, 0, -5461, "R2");
        idle(M + 3);

        done = 1'b1;
        report();
        $finish;
    end

endmodule